// File: doc/BRIEF.md
# Conditional Branch Predictor with Stall Accounting

This block predicts conditional branches with a direct-mapped table of two-bit saturating counters and works out the stall cycles that each retiring instruction costs. Each cycle, at most one instruction is presented. It comes with its address, its kind and, for a conditional branch, the resolved outcome. In the same cycle the block returns the prediction made from the counter before the update, a mispredict flag and a stall count. At the next clock edge it moves the selected counter one step toward the outcome.

The block also keeps a one-bit marker that records whether the last presented instruction redirected fetch, either as a taken branch or as an unconditional jump. An instruction that carries an inline constant and sits right after such a redirect may straddle a fetch line. When it does, it costs one extra cycle. The block does not compute targets and does not redirect fetch. It is meant to sit beside a pipeline model or a performance counter unit.

Top module: `branch_predictor_penalty`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) clears every counter to 0 and clears the redirect marker. After reset every branch predicts not-taken, jump_mark is 0, and with no valid instruction the stall count is 0.
- R2: The counter is selected by address bits [6:1] (the default of 64 entries). Bit 0 and all bits above bit 6 do not affect the selection, so addresses that differ only in those bits share a counter.
- R3: For a valid conditional branch, pred_taken is bit 1 of the selected counter as it was before this branch updates it. For any other kind, or when inst_valid is low, pred_taken is 0.
- R4: A valid conditional branch that is taken raises its counter by 1, stopping at 3. One that is not taken lowers it by 1, stopping at 0. The new value is visible to the next instruction.
- R5: A valid conditional branch whose outcome differs from pred_taken raises mispredict in the same cycle and reports stall_cycles = 2. A correctly predicted branch reports mispredict 0 and stall_cycles 0.
- R6: After a valid instruction that is a taken conditional branch or a jump, jump_mark is 1. After any other valid instruction it is 0. In a cycle with inst_valid low it keeps its value.
- R7: A valid instruction of kind imm16 costs stall_cycles = 1 when jump_mark is 1 and address bits [4:1] are 1111b. Otherwise it costs 0.
- R8: A valid instruction of kind imm32 costs stall_cycles = 1 when jump_mark is 1 and address bits [4:1] are 1110b. Otherwise it costs 0.
- R9: Instructions that are not conditional branches, and cycles with inst_valid low, leave every counter unchanged and report mispredict 0. Kind codes on inst_kind are: 0 plain, 1 imm16, 2 imm32, 3 conditional branch, 4 jump.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| inst_valid | input | 1 | An instruction is presented this cycle |
| inst_kind | input | 3 | Instruction kind (0 plain, 1 imm16, 2 imm32, 3 branch, 4 jump) |
| inst_pc | input | PC_W (32) | Instruction address |
| inst_taken | input | 1 | Resolved outcome of a conditional branch |
| pred_taken | output | 1 | Prediction from the counter before the update |
| mispredict | output | 1 | Prediction differed from the outcome |
| stall_cycles | output | STALL_W (2) | Stall cycles charged to this instruction |
| jump_mark | output | 1 | The previous valid instruction redirected fetch |

## Verification
A counter that has drifted or aliased to the wrong entry is visible at the ports on the next branch that selects that entry. It shows up as a wrong pred_taken and a wrong mispredict with its two stall cycles. The bench therefore walks counters through both saturation limits and through aliased addresses, and it interleaves non-branch instructions and idle cycles before each probing branch. A corrupted redirect marker is visible within one instruction. It shows either directly on jump_mark or as a missing or spurious one-cycle constant penalty, at the two line-end address patterns and at addresses just off them.

// File: rtl/bp_pkg.sv
// Shared types and helpers for the branch predictor.
// Assumes counters are two bits wide and saturate at both ends.
package bp_pkg;

    typedef enum logic [2:0] {
        KIND_PLAIN  = 3'd0,
        KIND_IMM16  = 3'd1,
        KIND_IMM32  = 3'd2,
        KIND_BRANCH = 3'd3,
        KIND_JUMP   = 3'd4
    } inst_kind_e;

    localparam int CTR_W   = 2;
    localparam int CTR_MAX = (1 << CTR_W) - 1;

    // Move a saturating counter one step toward the outcome.
    function automatic logic [CTR_W-1:0] ctr_step(input logic [CTR_W-1:0] cur,
                                                  input logic up);
        logic [CTR_W-1:0] nxt;
        nxt = cur;
        if (up && cur != CTR_W'(CTR_MAX)) nxt = cur + 1'b1;
        if (!up && cur != '0)             nxt = cur - 1'b1;
        return nxt;
    endfunction

endpackage

// File: rtl/bp_counter_table.sv
// Direct-mapped table of saturating counters.
// Reads are combinational, so a lookup always sees the value from before
// the same-cycle update. Writes land at the rising edge. Reset is
// synchronous and active low, and it clears all entries.
module bp_counter_table
    import bp_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             wr_en,
    input  logic             wr_up,
    output logic [CTR_W-1:0] rd_ctr
);

    logic [CTR_W-1:0] ctr_q [ENTRIES];

    // Select the addressed counter.
    assign rd_ctr = ctr_q[rd_idx];

    // Clear on reset, otherwise step the addressed counter on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= '0;
        end else if (wr_en) begin
            ctr_q[rd_idx] <= ctr_step(rd_ctr, wr_up);
        end
    end

    // R4: at the top limit a taken update keeps the counter at its maximum.
    assert_sat_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_up && rd_ctr == CTR_W'(CTR_MAX))
        |=> ctr_q[$past(rd_idx)] == CTR_W'(CTR_MAX));

    // R4: at the bottom limit a not-taken update keeps the counter at zero.
    assert_sat_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_up && rd_ctr == '0) |=> ctr_q[$past(rd_idx)] == '0);

    // R4: below the top limit a taken update moves the counter up by one.
    assert_step_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_up && rd_ctr != CTR_W'(CTR_MAX))
        |=> ctr_q[$past(rd_idx)] == $past(rd_ctr) + 1'b1);

    // R9: an entry that is not written keeps its value.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_hold
        assert_entry_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && rd_idx == IDX_W'(g)) |=> $stable(ctr_q[g]));
    end

endmodule

// File: rtl/bp_fetch_penalty.sv
// Tracks whether the previous valid instruction redirected fetch. It
// charges one cycle to a constant-carrying instruction that follows a
// redirect and ends at the line boundary.
// Assumes instructions are aligned to 16 bits, so the line offset seen
// here is the address bits between bit 1 and the line size.
module bp_fetch_penalty
    import bp_pkg::*;
#(
    parameter int LINE_BYTES = 32,
    localparam int OFS_W     = $clog2(LINE_BYTES) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inst_valid,
    input  inst_kind_e       inst_kind,
    input  logic             inst_taken,
    input  logic [OFS_W-1:0] line_ofs,
    output logic             mark,
    output logic             fetch_stall
);

    localparam logic [OFS_W-1:0] LAST_HALF = '1;
    localparam logic [OFS_W-1:0] LAST_WORD = LAST_HALF - 1'b1;

    logic redirect;
    logic imm16_cross;
    logic imm32_cross;

    // A taken conditional branch or any jump redirects fetch.
    assign redirect = (inst_kind == KIND_BRANCH && inst_taken) || inst_kind == KIND_JUMP;

    // Record the redirect status of each valid instruction; idle cycles hold.
    always_ff @(posedge clk) begin
        if (!rst_n)          mark <= 1'b0;
        else if (inst_valid) mark <= redirect;
    end

    // Detect a constant field running past the end of the fetch line.
    assign imm16_cross = inst_kind == KIND_IMM16 && line_ofs == LAST_HALF;
    assign imm32_cross = inst_kind == KIND_IMM32 && line_ofs == LAST_WORD;

    // Charge one cycle only right after a redirect.
    assign fetch_stall = inst_valid && mark && (imm16_cross || imm32_cross);

    // R6: a redirecting instruction leaves the marker set.
    assert_mark_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (inst_valid && redirect) |=> mark);

    // R6: an idle cycle does not change the marker.
    assert_mark_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !inst_valid |=> $stable(mark));

    // R7: the line penalty needs a preceding redirect.
    assert_stall_needs_mark_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stall |-> mark);

endmodule

// File: rtl/branch_predictor_penalty.sv
// Top level: two-bit counter branch prediction with stall accounting.
// One instruction may be presented per cycle. The outputs are
// combinational on the presented instruction. State updates at the
// rising edge. Reset is synchronous and active low.
module branch_predictor_penalty
    import bp_pkg::*;
#(
    parameter int PC_W         = 32,
    parameter int ENTRIES      = 64,
    parameter int LINE_BYTES   = 32,
    parameter int MISS_PENALTY = 2,
    parameter int STALL_W      = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               inst_valid,
    input  logic [2:0]         inst_kind,
    input  logic [PC_W-1:0]    inst_pc,
    input  logic               inst_taken,
    output logic               pred_taken,
    output logic               mispredict,
    output logic [STALL_W-1:0] stall_cycles,
    output logic               jump_mark
);

    localparam int IDX_W = $clog2(ENTRIES);
    localparam int OFS_W = $clog2(LINE_BYTES) - 1;

    inst_kind_e       kind;
    logic             is_branch;
    logic [IDX_W-1:0] idx;
    logic [CTR_W-1:0] ctr;
    logic             fetch_stall;
    logic             pc_unused;

    // Decode the kind code and the branch qualifier.
    assign kind      = inst_kind_e'(inst_kind);
    assign is_branch = inst_valid && kind == KIND_BRANCH;

    // Index from halfword address bits; bit 0 is never set by aligned code.
    assign idx       = inst_pc[IDX_W:1];
    assign pc_unused = ^{inst_pc[PC_W-1:IDX_W+1], inst_pc[0]};

    bp_counter_table #(
        .ENTRIES (ENTRIES)
    ) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (idx),
        .wr_en  (is_branch),
        .wr_up  (inst_taken),
        .rd_ctr (ctr)
    );

    bp_fetch_penalty #(
        .LINE_BYTES (LINE_BYTES)
    ) u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .inst_valid  (inst_valid),
        .inst_kind   (kind),
        .inst_taken  (inst_taken),
        .line_ofs    (inst_pc[OFS_W:1]),
        .mark        (jump_mark),
        .fetch_stall (fetch_stall)
    );

    // Predict from the upper counter bit and compare with the outcome.
    assign pred_taken = is_branch && ctr[CTR_W-1];
    assign mispredict = is_branch && (ctr[CTR_W-1] != inst_taken);

    // A mispredict costs the fixed penalty; otherwise the line penalty applies.
    always_comb begin
        if (mispredict)       stall_cycles = STALL_W'(MISS_PENALTY);
        else if (fetch_stall) stall_cycles = STALL_W'(1);
        else                  stall_cycles = '0;
    end

    // R5: every mispredict is charged the fixed penalty.
    assert_miss_cost_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mispredict |-> stall_cycles == STALL_W'(MISS_PENALTY));

    // R9: no mispredict without a valid conditional branch.
    assert_miss_only_branch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!inst_valid || inst_kind != 3'd3) |-> !mispredict);

    // R3: a predicted-taken branch whose outcome is taken is not flagged.
    assert_pred_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_taken && inst_taken) |-> !mispredict);

endmodule

// File: tb/branch_predictor_penalty_test.sv
// Self-checking bench: a vector table walked in order, then directed
// tests for idle cycles and reset.
module branch_predictor_penalty_test;

    typedef struct packed {
        logic [2:0]  kind;
        logic [15:0] pc;
        logic        tk;
        logic        e_pred;
        logic        e_mis;
        logic [1:0]  e_stall;
        logic        e_mark;
    } vec_t;

    localparam int NV = 22;
    // kind: 0 plain, 1 imm16, 2 imm32, 3 branch, 4 jump
    localparam vec_t VEC [NV] = '{
        '{3'd3, 16'h0100, 1'b1, 1'b0, 1'b1, 2'd2, 1'b0}, // R5 c0:0->1
        '{3'd3, 16'h0100, 1'b1, 1'b0, 1'b1, 2'd2, 1'b1}, // R4 c0:1->2
        '{3'd3, 16'h0100, 1'b1, 1'b1, 1'b0, 2'd0, 1'b1}, // R3 c0:2->3
        '{3'd3, 16'h0180, 1'b1, 1'b1, 1'b0, 2'd0, 1'b1}, // R2 alias c0:3 sat
        '{3'd3, 16'h0101, 1'b0, 1'b1, 1'b1, 2'd2, 1'b1}, // R2 bit0 c0:3->2
        '{3'd0, 16'h011E, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0}, // R6 cleared
        '{3'd4, 16'h0200, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0}, // R6 jump
        '{3'd1, 16'h001E, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1}, // R7 hit
        '{3'd4, 16'h0000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0},
        '{3'd1, 16'h001C, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1}, // R7 off pattern
        '{3'd4, 16'h0000, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0},
        '{3'd2, 16'h003C, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1}, // R8 hit
        '{3'd2, 16'h001E, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0}, // R8 no mark
        '{3'd3, 16'h0100, 1'b0, 1'b1, 1'b1, 2'd2, 1'b0}, // R4 c0:2->1
        '{3'd3, 16'h0102, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0}, // R4 c1 floor
        '{3'd3, 16'h0100, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0}, // R4 c0:1->0
        '{3'd3, 16'h0100, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0}, // R4 c0 floor
        '{3'd3, 16'h000A, 1'b1, 1'b0, 1'b1, 2'd2, 1'b0}, // c5:0->1
        '{3'd3, 16'h000A, 1'b1, 1'b0, 1'b1, 2'd2, 1'b1}, // c5:1->2
        '{3'd0, 16'h000A, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1}, // R9 plain
        '{3'd4, 16'h000A, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0}, // R9 jump
        '{3'd3, 16'h000A, 1'b0, 1'b1, 1'b1, 2'd2, 1'b1}  // R9 c5 still 2
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inst_valid = 1'b0;
    logic [2:0]  inst_kind = 3'd0;
    logic [31:0] inst_pc = '0;
    logic        inst_taken = 1'b0;
    logic        pred_taken;
    logic        mispredict;
    logic [1:0]  stall_cycles;
    logic        jump_mark;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    branch_predictor_penalty uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .inst_valid   (inst_valid),
        .inst_kind    (inst_kind),
        .inst_pc      (inst_pc),
        .inst_taken   (inst_taken),
        .pred_taken   (pred_taken),
        .mispredict   (mispredict),
        .stall_cycles (stall_cycles),
        .jump_mark    (jump_mark)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Drive at the falling edge, then sample mid-phase before the rising edge.
    task automatic present(input logic v, input logic [2:0] k,
                           input logic [31:0] pc, input logic tk);
        @(negedge clk);
        inst_valid = v;
        inst_kind  = k;
        inst_pc    = pc;
        inst_taken = tk;
        #2;
    endtask

    task automatic check_all(input string req, input logic ep, input logic em,
                             input logic [1:0] es, input logic ek);
        check(req, "pred_taken",   32'(pred_taken),   32'(ep));
        check(req, "mispredict",   32'(mispredict),   32'(em));
        check(req, "stall_cycles", 32'(stall_cycles), 32'(es));
        check(req, "jump_mark",    32'(jump_mark),    32'(ek));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n      = 1'b0;
        inst_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #1000000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state with no instruction presented.
        present(1'b0, 3'd0, 32'h0, 1'b0);
        check_all("R1", 1'b0, 1'b0, 2'd0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            present(1'b1, VEC[i].kind, 32'(VEC[i].pc), VEC[i].tk);
            check_all($sformatf("vec%0d", i), VEC[i].e_pred, VEC[i].e_mis,
                      VEC[i].e_stall, VEC[i].e_mark);
        end

        // R6/R9: counter 5 is now 1 and the marker is 0. Set the marker with a jump.
        present(1'b1, 3'd4, 32'h40, 1'b0);
        // Idle cycle that carries a taken branch pattern at entry 5.
        present(1'b0, 3'd3, 32'h0A, 1'b1);
        check_all("R9 idle", 1'b0, 1'b0, 2'd0, 1'b1);
        present(1'b0, 3'd3, 32'h0A, 1'b1);
        check("R6", "jump_mark held", 32'(jump_mark), 32'd1);
        // Entry 5 must still be 1: not-taken is predicted correctly.
        present(1'b1, 3'd3, 32'h0A, 1'b0);
        check_all("R9 after idle", 1'b0, 1'b0, 2'd0, 1'b1);

        // R2: high address bits alias to the same entry (entry 7).
        present(1'b1, 3'd3, 32'h0000_000E, 1'b1);
        present(1'b1, 3'd3, 32'hFFFF_FF8E, 1'b1);
        present(1'b1, 3'd3, 32'h0000_008E, 1'b1);
        check_all("R2 high alias", 1'b1, 1'b0, 2'd0, 1'b1);

        // R1: reset clears a trained counter and the marker.
        do_reset();
        present(1'b0, 3'd0, 32'h0, 1'b0);
        check("R1", "jump_mark after reset", 32'(jump_mark), 32'd0);
        present(1'b1, 3'd3, 32'h0E, 1'b1);
        check_all("R1 cleared ctr", 1'b0, 1'b1, 2'd2, 1'b0);

        @(negedge clk);
        inst_valid = 1'b0;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule